// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block lets several requester ports share one small word memory and build semaphores on it. Each port can issue a reserving read, a conditional store, a reservation drop or a plain store, and it can raise a one-cycle exception pulse. The monitor keeps two reservation marks for every port. The first is a local flag that says the port holds a reservation. The second is a global entry that records which memory word the reservation covers.

A conditional store writes the memory only if both marks of the issuing port are still intact for the addressed word. One cycle later the port receives a status bit: 0 means the write happened. 1 means nothing was written, and software must repeat its whole read-modify-write sequence. Plain stores and winning conditional stores from other ports break a global entry that covers the word they write. The drop request and the exception clear the marks by different rules.

Top module: `excl_monitor`

## Requirements
- R1: A reserving read (op code 1) sets the local flag of its port, records the word it addresses in that port's global entry, and one clock later answers with rsp_valid=1, rsp_status=0 and the memory word as it was before that cycle's writes.
- R2: A drop request (op code 3) clears only the local flag of its port, so a later conditional store from that port fails.
- R3: Every conditional store (op code 2) clears both marks of its port, whether it writes or not, so a second conditional store without a new reserving read fails.
- R4: An exception pulse on a port clears both marks of that port only, so that port's next conditional store fails and the other ports keep their reservations.
- R5: A conditional store that returns status 1 leaves every memory byte unchanged.
- R6: Access size is 0 for byte, 1 for halfword and 2 for word. Write data sits right-justified in the port's data lane and goes into the byte lanes chosen by the low address bits, aligned to the size. Byte lanes not selected keep their old value.
- R7: A conditional store succeeds (status 0, memory written) only when its port's local flag is set and its global entry is valid and holds the addressed word.
- R8: A successful write by another port (plain store, op code 4, or winning conditional store) to the word held in a port's global entry breaks that entry. A port's own plain store does not break its own entry.
- R9: Addresses match at word granularity, so any byte address inside the reserved word counts as a match.
- R10: When more than one port writes the same word in one cycle, the lowest-numbered port wins. A losing conditional store returns status 1.
- R11: The response comes exactly one clock after the request. Reset clears all marks, all responses and the whole memory to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_op | input | NPORTS*3 | Per-port op code: 0 idle, 1 reserving read, 2 conditional store, 3 drop, 4 plain store |
| req_addr | input | NPORTS*AW | Per-port byte address |
| req_size | input | NPORTS*2 | Per-port access size: 0 byte, 1 halfword, 2 word |
| req_wdata | input | NPORTS*DW | Per-port right-justified write data |
| exc_pulse | input | NPORTS | Per-port exception pulse |
| rsp_valid | output | NPORTS | Response valid, one clock after a reserving read or conditional store |
| rsp_status | output | NPORTS | 1 when a conditional store performed no write |
| rsp_rdata | output | NPORTS*DW | Word read by a reserving read |

## Verification
The conditional store is tried in five situations:
- after a fresh reservation;
- after a drop request;
- after an exception on the same port and on the other port;
- after a foreign plain store to the reserved word;
- racing with another port to the same word.

Only the intended cause separates the success cases from the failure cases. A foreign store with the local flag still set isolates loss of the global entry. A store from the port itself shows that its own writes leave its entry intact. The next reserving read on the word confirms through the normal read path whether memory changed. Byte and halfword accesses at unaligned offsets inside a reserved word separate word-granular matching from exact-address matching, and they check lane placement.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_IDLE  = 3'd0,
    OP_LDEX  = 3'd1,
    OP_STEX  = 3'd2,
    OP_CLREX = 3'd3,
    OP_STORE = 3'd4
  } op_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/excl_mon_tag.sv
module excl_mon_tag #(
  parameter int WAW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_ex,
  input  logic           st_ex,
  input  logic           clr_ex,
  input  logic           exc,
  input  logic [WAW-1:0] word,
  input  logic           snoop_hit,
  output logic           local_o,
  output logic           gvalid_o,
  output logic [WAW-1:0] gaddr_o
);

  logic           local_q, local_d;
  logic           gvalid_q, gvalid_d;
  logic [WAW-1:0] gaddr_q;
  logic           gaddr_en;

  always_comb begin
    local_d  = local_q;
    gvalid_d = gvalid_q;
    gaddr_en = 1'b0;
    if (snoop_hit) gvalid_d = 1'b0;
    if (exc || st_ex) begin
      local_d  = 1'b0;
      gvalid_d = 1'b0;
    end else if (ld_ex) begin
      local_d  = 1'b1;
      gvalid_d = 1'b1;
      gaddr_en = 1'b1;
    end else if (clr_ex) begin
      local_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      local_q  <= 1'b0;
      gvalid_q <= 1'b0;
      gaddr_q  <= '0;
    end else begin
      local_q  <= local_d;
      gvalid_q <= gvalid_d;
      if (gaddr_en) gaddr_q <= word;
    end
  end

  assign local_o  = local_q;
  assign gvalid_o = gvalid_q;
  assign gaddr_o  = gaddr_q;

  AST_LDEX_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ex && !exc |=> local_q && gvalid_q && gaddr_q == $past(word)) else $error("ldex arm"); // R1
  AST_CLREX_LOCAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ex && !exc && !snoop_hit |=> !local_q && gvalid_q == $past(gvalid_q) && gaddr_q == $past(gaddr_q)) else $error("clrex"); // R2
  AST_STEX_DROPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    st_ex |=> !local_q && !gvalid_q) else $error("stex drop"); // R3
  AST_EXC_DROPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    exc |=> !local_q && !gvalid_q) else $error("exc drop"); // R4
  AST_SNOOP_BREAKS: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_hit && !ld_ex |=> !gvalid_q) else $error("snoop"); // R8

endmodule

// File: rtl/excl_mon_arb.sv
module excl_mon_arb #(
  parameter int NPORTS = 2,
  parameter int WAW    = 6
) (
  input  logic [NPORTS-1:0]     cand,
  input  logic [NPORTS*WAW-1:0] word_flat,
  output logic [NPORTS-1:0]     win
);

  always_comb begin
    for (int p = 0; p < NPORTS; p++) begin
      win[p] = cand[p];
      for (int q = 0; q < p; q++) begin
        if (cand[q] && word_flat[q*WAW +: WAW] == word_flat[p*WAW +: WAW]) win[p] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPORTS; p++) begin
      for (int q = 0; q < p; q++) begin
        AST_ONE_WINNER_PER_WORD: assert (!(win[p] && win[q] &&
          word_flat[q*WAW +: WAW] == word_flat[p*WAW +: WAW])) else $error("two winners"); // R10
      end
    end
  end

endmodule

// File: rtl/excl_mon_mem.sv
module excl_mon_mem #(
  parameter int NPORTS = 2,
  parameter int DW     = 32,
  parameter int WAW    = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORTS-1:0]      we,
  input  logic [NPORTS-1:0]      re,
  input  logic [NPORTS*WAW-1:0]  word_flat,
  input  logic [NPORTS*DW/8-1:0] be_flat,
  input  logic [NPORTS*DW-1:0]   wdata_flat,
  output logic [NPORTS*DW-1:0]   rdata_flat
);

  localparam int NB    = DW / 8;
  localparam int DEPTH = 1 << WAW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q [NPORTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int p = 0; p < NPORTS; p++) begin
        if (we[p]) begin
          for (int b = 0; b < NB; b++) begin
            if (be_flat[p*NB + b])
              mem_q[word_flat[p*WAW +: WAW]][b*8 +: 8] <= wdata_flat[p*DW + b*8 +: 8];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORTS; p++) rdata_q[p] <= '0;
    end else begin
      for (int p = 0; p < NPORTS; p++) begin
        if (re[p]) rdata_q[p] <= mem_q[word_flat[p*WAW +: WAW]];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPORTS; p++) rdata_flat[p*DW +: DW] = rdata_q[p];
  end

  always_comb begin
    for (int p = 0; p < NPORTS; p++) begin
      AST_WRITE_HAS_LANES: assert (!(we[p] === 1'b1) || be_flat[p*NB +: NB] != '0) else $error("empty write"); // R6
    end
  end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORTS*3-1:0]    req_op,
  input  logic [NPORTS*AW-1:0]   req_addr,
  input  logic [NPORTS*2-1:0]    req_size,
  input  logic [NPORTS*DW-1:0]   req_wdata,
  input  logic [NPORTS-1:0]      exc_pulse,
  output logic [NPORTS-1:0]      rsp_valid,
  output logic [NPORTS-1:0]      rsp_status,
  output logic [NPORTS*DW-1:0]   rsp_rdata
);

  localparam int NB  = DW / 8;
  localparam int OB  = $clog2(NB);
  localparam int WAW = AW - OB;
  localparam logic [1:0] SZ_MAX = 2'(OB);

  logic [NPORTS-1:0]      is_ld, is_st, is_clr, is_wr;
  logic [NPORTS*WAW-1:0]  word_flat;
  logic [NPORTS*NB-1:0]   be_flat;
  logic [NPORTS*DW-1:0]   wd_flat;
  logic [NPORTS-1:0]      tag_local, tag_gvalid;
  logic [NPORTS*WAW-1:0]  tag_gaddr;
  logic [NPORTS-1:0]      cand, win, snoop;
  logic [NPORTS-1:0]      rsp_valid_d, rsp_valid_q;
  logic [NPORTS-1:0]      rsp_status_d, rsp_status_q;

  // request decode: op, word address, byte lanes, lane-shifted data
  always_comb begin
    for (int p = 0; p < NPORTS; p++) begin
      op_e           op;
      logic [1:0]    sz;
      logic [OB-1:0] lo, alo;
      int            nbytes;
      op = op_e'(req_op[p*3 +: 3]);
      is_ld[p]  = (op == OP_LDEX);
      is_st[p]  = (op == OP_STEX);
      is_clr[p] = (op == OP_CLREX);
      is_wr[p]  = (op == OP_STORE);
      word_flat[p*WAW +: WAW] = req_addr[p*AW + OB +: WAW];
      lo  = req_addr[p*AW +: OB];
      sz  = (req_size[p*2 +: 2] > SZ_MAX) ? SZ_MAX : req_size[p*2 +: 2];
      nbytes = 1 << sz;
      alo = lo & ~OB'(nbytes - 1);
      be_flat[p*NB +: NB] = NB'((((NB+1)'(1)) << nbytes) - (NB+1)'(1)) << alo;
      wd_flat[p*DW +: DW] = req_wdata[p*DW +: DW] << {alo, 3'b000};
    end
  end

  // eligibility of conditional stores and write candidates
  always_comb begin
    for (int p = 0; p < NPORTS; p++) begin
      cand[p] = is_wr[p] || (is_st[p] && tag_local[p] && tag_gvalid[p] &&
                tag_gaddr[p*WAW +: WAW] == word_flat[p*WAW +: WAW]);
    end
  end

  excl_mon_arb #(.NPORTS(NPORTS), .WAW(WAW)) u_arb (
    .cand      (cand),
    .word_flat (word_flat),
    .win       (win)
  );

  // foreign winning writes break global entries
  always_comb begin
    for (int p = 0; p < NPORTS; p++) begin
      snoop[p] = 1'b0;
      for (int q = 0; q < NPORTS; q++) begin
        if (q != p && win[q] && word_flat[q*WAW +: WAW] == tag_gaddr[p*WAW +: WAW])
          snoop[p] = 1'b1;
      end
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_tag
    excl_mon_tag #(.WAW(WAW)) u_tag (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_ex     (is_ld[p]),
      .st_ex     (is_st[p]),
      .clr_ex    (is_clr[p]),
      .exc       (exc_pulse[p]),
      .word      (word_flat[p*WAW +: WAW]),
      .snoop_hit (snoop[p]),
      .local_o   (tag_local[p]),
      .gvalid_o  (tag_gvalid[p]),
      .gaddr_o   (tag_gaddr[p*WAW +: WAW])
    );
  end

  excl_mon_mem #(.NPORTS(NPORTS), .DW(DW), .WAW(WAW)) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (win),
    .re         (is_ld | is_st),
    .word_flat  (word_flat),
    .be_flat    (be_flat),
    .wdata_flat (wd_flat),
    .rdata_flat (rsp_rdata)
  );

  always_comb begin
    rsp_valid_d  = is_ld | is_st;
    rsp_status_d = is_st & ~win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q  <= '0;
      rsp_status_q <= '0;
    end else begin
      rsp_valid_q  <= rsp_valid_d;
      rsp_status_q <= rsp_status_d;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_status = rsp_status_q;

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ld[p] || is_st[p]) |=> rsp_valid[p]) else $error("late rsp"); // R11
    AST_STATUS_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_status[p] |-> rsp_valid[p]) else $error("stray status"); // R5
    AST_STEX_NEEDS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      is_st[p] && !tag_local[p] |=> rsp_status[p]) else $error("stex without tag"); // R7
  end

endmodule

// File: tb/excl_monitor_test.sv
`timescale 1ns/1ps
module excl_monitor_test;

  localparam logic [2:0] I = 3'd0, L = 3'd1, S = 3'd2, C = 3'd3, W = 3'd4;

  typedef struct packed {
    logic [2:0]  op0; logic [7:0] a0; logic [1:0] s0; logic [31:0] d0;
    logic [2:0]  op1; logic [7:0] a1; logic [1:0] s1; logic [31:0] d1;
    logic [1:0]  exc;
    logic        e0;  logic [31:0] r0;
    logic        e1;  logic [31:0] r1;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{W,8'h10,2'd2,32'h11223344, I,8'h00,2'd0,32'h0, 2'b00, 1'b0,32'h0,        1'b0,32'h0,        4'd1},  // R1 setup
    '{L,8'h10,2'd2,32'h0,        I,8'h00,2'd0,32'h0, 2'b00, 1'b0,32'h11223344, 1'b0,32'h0,        4'd1},  // R1
    '{S,8'h10,2'd2,32'hAAAA0001, I,8'h00,2'd0,32'h0, 2'b00, 1'b0,32'h0,        1'b0,32'h0,        4'd7},  // R7
    '{S,8'h10,2'd2,32'h0000BBBB, I,8'h00,2'd0,32'h0, 2'b00, 1'b1,32'h0,        1'b0,32'h0,        4'd3},  // R3
    '{L,8'h10,2'd2,32'h0,        I,8'h00,2'd0,32'h0, 2'b00, 1'b0,32'hAAAA0001, 1'b0,32'h0,        4'd5},  // R5
    '{C,8'h10,2'd2,32'h0,        I,8'h00,2'd0,32'h0, 2'b00, 1'b0,32'h0,        1'b0,32'h0,        4'd2},  // R2
    '{S,8'h10,2'd2,32'h00000005, I,8'h00,2'd0,32'h0, 2'b00, 1'b1,32'h0,        1'b0,32'h0,        4'd2},  // R2
    '{L,8'h10,2'd2,32'h0,        I,8'h00,2'd0,32'h0, 2'b00, 1'b0,32'hAAAA0001, 1'b0,32'h0,        4'd5},  // R5
    '{I,8'h00,2'd0,32'h0,        I,8'h00,2'd0,32'h0, 2'b01, 1'b0,32'h0,        1'b0,32'h0,        4'd4},  // R4
    '{S,8'h10,2'd2,32'h00000005, I,8'h00,2'd0,32'h0, 2'b00, 1'b1,32'h0,        1'b0,32'h0,        4'd4},  // R4
    '{L,8'h11,2'd0,32'h0,        L,8'h20,2'd2,32'h0, 2'b00, 1'b0,32'hAAAA0001, 1'b0,32'h0,        4'd9},  // R9
    '{S,8'h13,2'd0,32'h000000CC, I,8'h00,2'd0,32'h0, 2'b00, 1'b0,32'h0,        1'b0,32'h0,        4'd9},  // R9
    '{L,8'h10,2'd2,32'h0,        I,8'h00,2'd0,32'h0, 2'b00, 1'b0,32'hCCAA0001, 1'b0,32'h0,        4'd6},  // R6
    '{I,8'h00,2'd0,32'h0,        W,8'h22,2'd1,32'h1234, 2'b00, 1'b0,32'h0,     1'b0,32'h0,        4'd8},  // R8 own store
    '{I,8'h00,2'd0,32'h0,        S,8'h20,2'd2,32'hBEEF, 2'b00, 1'b0,32'h0,     1'b0,32'h0,        4'd8},  // R8
    '{L,8'h10,2'd2,32'h0,        I,8'h00,2'd0,32'h0, 2'b00, 1'b0,32'hCCAA0001, 1'b0,32'h0,        4'd8},  // R8
    '{I,8'h00,2'd0,32'h0,        W,8'h12,2'd0,32'h77, 2'b00, 1'b0,32'h0,       1'b0,32'h0,        4'd8},  // R8
    '{S,8'h10,2'd2,32'h00000009, I,8'h00,2'd0,32'h0, 2'b00, 1'b1,32'h0,        1'b0,32'h0,        4'd8},  // R8
    '{L,8'h30,2'd2,32'h0,        L,8'h30,2'd2,32'h0, 2'b00, 1'b0,32'h0,        1'b0,32'h0,        4'd10}, // R10
    '{S,8'h30,2'd2,32'h000000A0, S,8'h30,2'd2,32'hB0, 2'b00, 1'b0,32'h0,       1'b1,32'h0,        4'd10}, // R10
    '{L,8'h30,2'd2,32'h0,        I,8'h00,2'd0,32'h0, 2'b00, 1'b0,32'h000000A0, 1'b0,32'h0,        4'd10}, // R10
    '{L,8'h10,2'd1,32'h0,        L,8'h20,2'd2,32'h0, 2'b00, 1'b0,32'hCC770001, 1'b0,32'h0000BEEF, 4'd6},  // R6
    '{S,8'h10,2'd1,32'h0000FFFF, S,8'h22,2'd1,32'h5555, 2'b00, 1'b0,32'h0,     1'b0,32'h0,        4'd6},  // R6
    '{L,8'h10,2'd2,32'h0,        L,8'h20,2'd2,32'h0, 2'b00, 1'b0,32'hCC77FFFF, 1'b0,32'h5555BEEF, 4'd6}   // R6
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  req_op;
  logic [15:0] req_addr;
  logic [3:0]  req_size;
  logic [63:0] req_wdata;
  logic [1:0]  exc_pulse;
  logic [1:0]  rsp_valid, rsp_status;
  logic [63:0] rsp_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  excl_monitor uut (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .exc_pulse(exc_pulse),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata)
  );

  task automatic step(input vec_t v);
    req_op    = {v.op1, v.op0};
    req_addr  = {v.a1, v.a0};
    req_size  = {v.s1, v.s0};
    req_wdata = {v.d1, v.d0};
    exc_pulse = v.exc;
    @(posedge clk);
    @(negedge clk);
    req_op = '0; exc_pulse = '0;
  endtask

  task automatic check_port(input int p, input logic [2:0] op, input logic est,
                            input logic [31:0] erd, input int rq);
    if (op == L || op == S) begin
      total++;
      if (rsp_valid[p] !== 1'b1 || rsp_status[p] !== est) begin
        bad++;
        $display("FAIL R%0d port %0d response: got valid=%b status=%b expected valid=1 status=%b",
                 rq, p, rsp_valid[p], rsp_status[p], est);
      end
      if (op == L) begin
        total++;
        if (rsp_rdata[p*32 +: 32] !== erd) begin
          bad++;
          $display("FAIL R%0d port %0d rdata: got %h expected %h", rq, p, rsp_rdata[p*32 +: 32], erd);
        end
      end
    end else begin
      total++;
      if (rsp_valid[p] !== 1'b0) begin
        bad++;
        $display("FAIL R%0d port %0d valid: got %b expected 0", rq, p, rsp_valid[p]);
      end
    end
  endtask

  task automatic run(input vec_t v);
    step(v);
    check_port(0, v.op0, v.e0, v.r0, int'(v.rq));
    check_port(1, v.op1, v.e1, v.r1, int'(v.rq));
  endtask

  function automatic vec_t mk(input logic [2:0] op0, input logic [7:0] a0, input logic [31:0] d0,
                              input logic [1:0] exc, input logic e0, input logic [31:0] r0,
                              input logic [3:0] rq);
    vec_t v;
    v = '0;
    v.op0 = op0; v.a0 = a0; v.s0 = 2'd2; v.d0 = d0;
    v.exc = exc; v.e0 = e0; v.r0 = r0; v.rq = rq;
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired before the run ended");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_op = '0; req_addr = '0; req_size = '0; req_wdata = '0; exc_pulse = '0;
    do_reset();
    // R11: reset state of the response outputs
    total++;
    if (rsp_valid !== 2'b00 || rsp_status !== 2'b00) begin
      bad++;
      $display("FAIL R11 reset: got valid=%b status=%b expected 00 00", rsp_valid, rsp_status);
    end
    // R11: conditional store straight after reset finds no reservation
    run(mk(S, 8'h10, 32'h1, 2'b00, 1'b1, 32'h0, 4'd11));
    // R11: memory read after reset is zero
    run(mk(L, 8'h10, 32'h0, 2'b00, 1'b0, 32'h0, 4'd11));
    run(mk(S, 8'h10, 32'h0, 2'b00, 1'b0, 32'h0, 4'd11));

    for (int k = 0; k < NV; k++) run(VECS[k]);

    // R4: exception on port 1 leaves port 0 reservation intact
    run(mk(L, 8'h10, 32'h0, 2'b00, 1'b0, 32'hCC77FFFF, 4'd4));
    run(mk(I, 8'h00, 32'h0, 2'b10, 1'b0, 32'h0, 4'd4));
    run(mk(S, 8'h10, 32'h12345678, 2'b00, 1'b0, 32'h0, 4'd4));
    run(mk(L, 8'h10, 32'h0, 2'b00, 1'b0, 32'h12345678, 4'd4));

    // R11: mid-run reset clears reservations and memory
    run(mk(L, 8'h30, 32'h0, 2'b00, 1'b0, 32'h000000A0, 4'd11));
    do_reset();
    total++;
    if (rsp_valid !== 2'b00) begin
      bad++;
      $display("FAIL R11 reset valid: got %b expected 00", rsp_valid);
    end
    run(mk(S, 8'h30, 32'h1, 2'b00, 1'b1, 32'h0, 4'd11));
    run(mk(L, 8'h30, 32'h0, 2'b00, 1'b0, 32'h0, 4'd11));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule